// File: doc/BRIEF.md
# Channel Input Glitch Filter

This block conditions one asynchronous timer-channel input before edge detection. The raw pin first crosses into the system clock domain through a two-flop synchronizer. It then passes through a digital glitch filter whose qualification counter advances once every four system clocks. A level survives the filter only when it holds for longer than the programmed window. A change that survives reaches an edge detector, which sets a sticky channel flag for the rising edge, the falling edge or both, as selected.

A 4-bit filter value `N` sets the window. With `N = 0` the filter is bypassed and the input reaches the flag after three system-clock rising edges. With `N > 0` the flag sets exactly `4 + 4*N` system clocks after the input changes. A pulse of `4*N` clocks or less never reaches the edge detector.

The filter is a two-state machine:
- **ST_STABLE**: the filtered level matches the synchronized input.
- **ST_QUALIFY**: a differing level is being timed.

The machine has four transitions:
- **start** (ST_STABLE to ST_QUALIFY): the synchronized input differs from the filtered level. The counter and the divide-by-4 prescaler both restart from zero.
- **reject** (ST_QUALIFY to ST_STABLE): the input returns to the filtered level before the window expires. The filtered level is left unchanged.
- **accept** (ST_QUALIFY to ST_STABLE): a prescaler tick brings the count to `N`. The filtered level takes the new value.
- **bypass** (ST_QUALIFY to ST_STABLE): the filter value becomes zero. The filtered level takes the input at once.

While the machine is in ST_STABLE with `N = 0`, the filtered level copies the synchronized input on every clock.

Top module: `chan_glitch_filter`

## Requirements
- R1: With filter value 0, a change on `raw_in` sets `chan_flag` at the 3rd rising clock edge after the change. A pulse as short as one clock is passed.
- R2: With filter value N > 0, `filt_level` takes a held new level at the (3 + 4*N)th rising edge after the change, and `chan_flag` sets at the (4 + 4*N)th.
- R3: The qualification counter changes only on the clock where the free-running 2-bit prescaler is at its terminal value 3. The prescaler restarts at 0 on each start transition.
- R4: With N > 0, a pulse lasting 4*N clocks or fewer leaves `filt_level` unchanged and never sets `chan_flag`.
- R5: With N > 0, a pulse lasting 4*N + 1 clocks or more is accepted.
- R6: `edge_sel` bit 0 enables flagging of rising filtered edges, and bit 1 enables flagging of falling ones. The value 00 flags nothing.
- R7: `chan_flag` stays set until `flag_clr` is sampled high at a rising edge. If a new edge is detected at that same edge, the flag stays set.
- R8: Synchronous reset (`rst` high) clears the synchronizer, filtered level, edge history, counter and flag to 0. With `raw_in` low, no flag appears after reset.
- R9: With filter value 0, `filt_level` follows `raw_in` with a latency of 3 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Asynchronous channel input |
| filt_val | input | 4 | Filter window N, in units of 4 clocks (0 = bypass) |
| edge_sel | input | 2 | Bit 0 enables rising edges, bit 1 enables falling edges |
| flag_clr | input | 1 | Clears the channel flag |
| filt_level | output | 1 | Filtered input level |
| chan_flag | output | 1 | Sticky edge flag |

## Verification
The hardest situation to reach is the exact boundary between a rejected pulse and an accepted one. A pulse of 4*N clocks and a pulse of 4*N + 1 clocks differ only in whether the synchronized input is still held on the single prescaler tick that completes the count. A phase error of one clock in the prescaler realignment would move that boundary. The bench therefore sweeps every filter value from 0 to 4 against every pulse width from 1 to 4*N + 3 clocks. For each pulse it records the exact cycle at which the level and the flag first change, and compares both with the closed-form latency.

// File: rtl/cgf_pkg.sv
package cgf_pkg;
    typedef enum logic [0:0] {
        ST_STABLE  = 1'b0,
        ST_QUALIFY = 1'b1
    } filt_state_t;

    localparam int SEL_RISE = 0;
    localparam int SEL_FALL = 1;
endpackage

// File: rtl/cgf_sync.sv
module cgf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cgf_filter.sv
module cgf_filter
    import cgf_pkg::*;
#(
    parameter int VAL_W = 4,
    parameter int CNT_W = 5,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic [VAL_W-1:0] fval,
    output logic             level_q,
    output logic             det_level
);
    localparam logic [DIV_W-1:0] PH_LAST = '1;

    filt_state_t      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] ph_q, ph_d;
    logic             level_d;
    logic             bypass, tick, differs, done;
    logic [CNT_W-1:0] target;

    assign bypass  = (fval == '0);
    assign tick    = (ph_q == PH_LAST);
    assign differs = (sync_in != level_q);
    assign target  = CNT_W'(fval);
    assign done    = tick && ((cnt_q + 1'b1) == target);

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_STABLE;
        else     st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STABLE: begin
                if (!bypass && differs) st_d = ST_QUALIFY;      // start
            end
            ST_QUALIFY: begin
                if (!differs)   st_d = ST_STABLE;               // reject
                else if (bypass) st_d = ST_STABLE;              // bypass
                else if (done)  st_d = ST_STABLE;               // accept
            end
            default: st_d = ST_STABLE;
        endcase
    end

    // Datapath outputs
    always_comb begin
        cnt_d   = cnt_q;
        ph_d    = ph_q + 1'b1;
        level_d = level_q;
        unique case (st_q)
            ST_STABLE: begin
                if (bypass) begin
                    level_d = sync_in;
                end else if (differs) begin
                    cnt_d = '0;
                    ph_d  = '0;
                end
            end
            ST_QUALIFY: begin
                if (!differs) begin
                    cnt_d = '0;
                end else if (bypass || done) begin
                    level_d = sync_in;
                    cnt_d   = '0;
                end else if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ph_q    <= '0;
            level_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            ph_q    <= ph_d;
            level_q <= level_d;
        end
    end

    assign det_level = bypass ? sync_in : level_q;

    // R3: counter only moves on a prescaler tick while qualifying
    p_tick_only_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_QUALIFY && $past(st_q) == ST_QUALIFY && cnt_q != $past(cnt_q))
        |-> ($past(ph_q) == PH_LAST));

    // R4: with filtering on, the level only moves out of qualification to the input value
    p_level_qualified_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(fval) != '0 && level_q != $past(level_q))
        |-> ($past(st_q) == ST_QUALIFY && $past(sync_in) == level_q));
endmodule

// File: rtl/cgf_edge.sv
module cgf_edge
    import cgf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       level,
    input  logic [1:0] sel,
    input  logic       clr,
    output logic       flag_q
);
    logic prev_q;
    logic rise, fall, hit;

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
    assign hit  = (rise & sel[SEL_RISE]) | (fall & sel[SEL_FALL]);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= level;
            if (hit)      flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
        end
    end

    // R7: flag holds without a clear
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

    // R6: flag rises only after a level change was seen
    p_flag_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(level != prev_q));
endmodule

// File: rtl/chan_glitch_filter.sv
module chan_glitch_filter #(
    parameter int VAL_W       = 4,
    parameter int CNT_W       = 5,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_in,
    input  logic [VAL_W-1:0] filt_val,
    input  logic [1:0]       edge_sel,
    input  logic             flag_clr,
    output logic             filt_level,
    output logic             chan_flag
);
    logic sync_lvl;
    logic det_lvl;

    cgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (sync_lvl)
    );

    cgf_filter #(.VAL_W(VAL_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_lvl),
        .fval      (filt_val),
        .level_q   (filt_level),
        .det_level (det_lvl)
    );

    cgf_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .level  (det_lvl),
        .sel    (edge_sel),
        .clr    (flag_clr),
        .flag_q (chan_flag)
    );

    // R8: first cycle after reset is quiet
    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!chan_flag && !filt_level));
endmodule

// File: tb/test_chan_glitch_filter.sv
module test_chan_glitch_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raw_in = 1'b0;
    logic [3:0] filt_val = 4'd0;
    logic [1:0] edge_sel = 2'b11;
    logic       flag_clr = 1'b0;
    logic       filt_level;
    logic       chan_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;   // 250 MHz

    chan_glitch_filter i_chan_glitch_filter (
        .clk        (clk),
        .rst        (rst),
        .raw_in     (raw_in),
        .filt_val   (filt_val),
        .edge_sel   (edge_sel),
        .flag_clr   (flag_clr),
        .filt_level (filt_level),
        .chan_flag  (chan_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    // Drive raw_in to nv at the current negedge; hold>0 reverts after hold clocks.
    task automatic watch(input logic nv, input int hold, input int span,
                         output int ff, output int fl);
        logic start_lvl;
        start_lvl = filt_level;
        ff = -1;
        fl = -1;
        raw_in = nv;
        for (int i = 1; i <= span; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (chan_flag && ff < 0) ff = i;
            if (filt_level != start_lvl && fl < 0) fl = i;
            if (hold > 0 && i == hold) raw_in = ~nv;
        end
    endtask

    initial begin
        int ff, fl, bad;
        // R8: reset state and quiet start
        repeat (4) @(negedge clk);
        rst = 1'b0;
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (chan_flag || filt_level) bad++;
        end
        chk(bad == 0, "R8 reset quiet", bad, 0);

        // Sweep filter value vs pulse width (R1, R2, R4, R5, R9)
        edge_sel = 2'b11;
        for (int n = 0; n <= 4; n++) begin
            for (int w = 1; w <= 4*n + 3; w++) begin
                bit acc;
                int ef, el;
                filt_val = 4'(n);
                raw_in = 1'b0;
                repeat (4*n + 10) @(negedge clk);
                clear_flag();
                watch(1'b1, w, w + 4*n + 12, ff, fl);
                acc = (n == 0) || (w >= 4*n + 1);
                ef = acc ? ((n == 0) ? 3 : 4 + 4*n) : -1;
                el = acc ? 3 + 4*n : -1;
                if (n == 0) begin
                    chk(ff == ef, "R1 bypass flag latency", ff, ef);
                    chk(fl == el, "R9 bypass level latency", fl, el);
                end else if (acc) begin
                    chk(ff == ef, "R2 flag latency", ff, ef);
                    chk(fl == el, "R5 level accepted", fl, el);
                end else begin
                    chk(ff == ef, "R4 glitch no flag", ff, ef);
                    chk(fl == el, "R4 glitch level held", fl, el);
                end
            end
        end

        // R6: edge selection, N=1 (flag latency 8); R3 via exact latency
        filt_val = 4'd1;
        raw_in = 1'b0;
        edge_sel = 2'b01;
        repeat (16) @(negedge clk);
        clear_flag();
        watch(1'b1, 0, 20, ff, fl);
        chk(ff == 8, "R6 rise enabled", ff, 8);
        chk(fl == 7, "R3 prescaled level latency", fl, 7);
        clear_flag();
        watch(1'b0, 0, 20, ff, fl);
        chk(ff == -1, "R6 fall masked", ff, -1);
        edge_sel = 2'b10;
        clear_flag();
        watch(1'b1, 0, 20, ff, fl);
        chk(ff == -1, "R6 rise masked", ff, -1);
        clear_flag();
        watch(1'b0, 0, 20, ff, fl);
        chk(ff == 8, "R6 fall enabled", ff, 8);
        edge_sel = 2'b00;
        clear_flag();
        watch(1'b1, 0, 20, ff, fl);
        chk(ff == -1, "R6 none rise", ff, -1);
        watch(1'b0, 0, 20, ff, fl);
        chk(ff == -1, "R6 none fall", ff, -1);

        // R7: set wins over clear, sticky, clear works
        filt_val = 4'd0;
        edge_sel = 2'b11;
        repeat (8) @(negedge clk);
        clear_flag();
        raw_in = 1'b1;
        @(negedge clk);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk(chan_flag == 1'b1, "R7 set beats clear", int'(chan_flag), 1);
        repeat (10) @(negedge clk);
        chk(chan_flag == 1'b1, "R7 sticky", int'(chan_flag), 1);
        clear_flag();
        chk(chan_flag == 1'b0, "R7 cleared", int'(chan_flag), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule